// File: doc/BRIEF.md
# Core Voltage Reference and Power-Good Monitor

This block turns a 5-bit voltage-identification code into a digital core reference in millivolts. It also judges sampled output voltages against windows built from that reference. The core output, two linear-regulator feedback voltages and an auxiliary switcher voltage arrive as unsigned millivolt codes. They are taken in only on a one-cycle sample strobe.

On each strobe the block updates two registered flags. Power-good requires the core to sit inside a hysteretic window around the reference and every other rail to be above its under-voltage level. Core over-voltage flags a core above 115% of the reference. All threshold tests are exact integer cross-multiplications, with the core scaled by 100 against the reference scaled by the percentage. Power-good stays low until soft-start is reported done. It is forced good while the reserved all-ones code is applied.

Top module: `vid_pgood_mon`

## Requirements
- R1: When code bit 4 is 0, `ref_mv` equals 2050 minus 50 times the value of code bits 3..0 (2050 at 00000, 1300 at 01111).
- R2: When code bit 4 is 1 and the code is not 11111, `ref_mv` equals 3500 minus 100 times the value of code bits 3..0 (3500 at 10000, 2100 at 11110).
- R3: Code 11111 is reserved. `ref_mv` reads 0, `ovp` is 0 and, with soft-start done, `pgood` is 1 whatever the sampled voltages. Both core window flags restart from their cleared state.
- R4: The core-high condition sets when core×100 > ref×110. It clears when core×100 < ref×108 and otherwise holds its state. While it is set, `pgood` is 0.
- R5: The core-above-low condition sets when core×100 ≥ ref×94. It clears when core×100 < ref×92 and otherwise holds its state. While it is clear, `pgood` is 0.
- R6: Linear rail A (target `LIN_A_MV`, default 1500) and linear rail B (target `LIN_B_MV`, default 1800) are each under voltage when value×4 < target×3. Either one under voltage makes `pgood` 0.
- R7: With `aux_sel` = 0 the auxiliary rail is under voltage when aux×4 < 1500×3. With `aux_sel` = 1 it is under voltage when aux < 2475. Under voltage makes `pgood` 0.
- R8: On a strobe with a non-reserved code, `ovp` becomes 1 exactly when core×100 > ref×115, and 0 otherwise. `ovp` = 1 always comes with `pgood` = 0.
- R9: A strobe with `ss_done` = 0 makes `pgood` 0, whatever the code.
- R10: `pgood`, `ovp` and the window state change only on a clock edge where `smp` is 1. Input changes without a strobe have no effect on them.
- R11: A synchronous reset (`rst` = 1 at a rising edge) clears `pgood`, `ovp` and both core window conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid | input | 5 | Voltage-identification code |
| smp | input | 1 | Sample strobe, one cycle per new set of voltages |
| core_mv | input | MV_W | Core output voltage, millivolts |
| lin_a_mv | input | MV_W | Linear rail A feedback voltage, millivolts |
| lin_b_mv | input | MV_W | Linear rail B feedback voltage, millivolts |
| aux_mv | input | MV_W | Auxiliary switcher voltage, millivolts |
| aux_sel | input | 1 | Auxiliary mode: 0 regulated, 1 pass-through |
| ss_done | input | 1 | Soft-start complete |
| ref_mv | output | MV_W | Decoded core reference, millivolts (0 for reserved code) |
| pgood | output | 1 | Registered power-good flag |
| ovp | output | 1 | Registered core over-voltage flag |

## Verification
A corrupted hysteresis bit does not show at once. It shows only on the first strobe where the core sits in a 2% release band, between 108% and 110% or between 92% and 94%. There `pgood` then takes the wrong value, one cycle after that strobe. For this reason the sweep walks each code's core voltage up and back down through both bands. The reference decode is combinational, so a wrong step or range shows on `ref_mv` in the same cycle the code is applied.

// File: rtl/vid_pgood_mon.sv
module vid_pgood_mon #(
  parameter int MV_W          = 13,
  parameter int LIN_A_MV      = 1500,
  parameter int LIN_B_MV      = 1800,
  parameter int AUX_REF_MV    = 1500,
  parameter int AUX_FIX_UV_MV = 2475
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      vid,
  input  logic            smp,
  input  logic [MV_W-1:0] core_mv,
  input  logic [MV_W-1:0] lin_a_mv,
  input  logic [MV_W-1:0] lin_b_mv,
  input  logic [MV_W-1:0] aux_mv,
  input  logic            aux_sel,
  input  logic            ss_done,
  output logic [MV_W-1:0] ref_mv,
  output logic            pgood,
  output logic            ovp
);
  localparam int PW = MV_W + 8;

  function automatic logic [PW-1:0] scale(input logic [MV_W-1:0] v, input int k);
    return PW'(v) * PW'(k);
  endfunction

  function automatic logic under(input logic [MV_W-1:0] v, input int tgt);
    return (PW'(v) * PW'(4)) < (PW'(tgt) * PW'(3));
  endfunction

  logic            rsv;
  logic [PW-1:0]   core_x;
  logic            hi_q, lo_q, hi_nx, lo_nx, rails_ok, pg_nx, ov_nx;

  assign rsv = &vid;

  always_comb begin
    if (rsv)         ref_mv = '0;
    else if (vid[4]) ref_mv = MV_W'(3500) - MV_W'(100) * MV_W'(vid[3:0]);
    else             ref_mv = MV_W'(2050) - MV_W'(50) * MV_W'(vid[3:0]);
  end

  assign core_x = scale(core_mv, 100);

  always_comb begin
    hi_nx = hi_q;
    lo_nx = lo_q;
    if (rsv) begin
      hi_nx = 1'b0;
      lo_nx = 1'b0;
    end else begin
      if (core_x > scale(ref_mv, 110))       hi_nx = 1'b1;
      else if (core_x < scale(ref_mv, 108))  hi_nx = 1'b0;
      if (core_x >= scale(ref_mv, 94))       lo_nx = 1'b1;
      else if (core_x < scale(ref_mv, 92))   lo_nx = 1'b0;
    end
  end

  assign rails_ok = !under(lin_a_mv, LIN_A_MV) && !under(lin_b_mv, LIN_B_MV) &&
                    (aux_sel ? (PW'(aux_mv) >= PW'(AUX_FIX_UV_MV)) : !under(aux_mv, AUX_REF_MV));
  assign pg_nx = ss_done && (rsv || (lo_nx && !hi_nx && rails_ok));
  assign ov_nx = !rsv && (core_x > scale(ref_mv, 115));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      pgood <= 1'b0;
      ovp   <= 1'b0;
    end else if (smp) begin
      hi_q  <= hi_nx;
      lo_q  <= lo_nx;
      pgood <= pg_nx;
      ovp   <= ov_nx;
    end
  end

  p_ref_range_r2: assert property (@(posedge clk) disable iff (rst)
    !rsv |-> (ref_mv >= MV_W'(1300) && ref_mv <= MV_W'(3500)));

  p_rsv_good_r3: assert property (@(posedge clk) disable iff (rst)
    (smp && rsv && ss_done) |=> (pgood && !ovp));

  p_ovp_excl_r8: assert property (@(posedge clk) disable iff (rst)
    ovp |-> !pgood);

  p_ss_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (smp && !ss_done) |=> !pgood);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !smp |=> ($stable(pgood) && $stable(ovp)));

  p_hi_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (hi_q && !rsv) |-> !pgood);
endmodule

// File: tb/sim_vid_pgood_mon.sv
module sim_vid_pgood_mon;
  localparam int CLK_PERIOD = 10;
  localparam int W = 13;

  logic clk = 1'b0, rst = 1'b1, smp = 1'b0, aux_sel = 1'b0, ss_done = 1'b0;
  logic [4:0] vid = '0;
  logic [W-1:0] core_mv = '0, lin_a_mv = '0, lin_b_mv = '0, aux_mv = '0;
  logic [W-1:0] ref_mv;
  logic pgood, ovp;

  int n_chk = 0, n_bad = 0;
  bit m_hi = 0, m_lo = 0, m_pg = 0, m_ov = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_pgood_mon u0 (.clk(clk), .rst(rst), .vid(vid), .smp(smp), .core_mv(core_mv),
    .lin_a_mv(lin_a_mv), .lin_b_mv(lin_b_mv), .aux_mv(aux_mv), .aux_sel(aux_sel),
    .ss_done(ss_done), .ref_mv(ref_mv), .pgood(pgood), .ovp(ovp));

  function automatic int exp_ref(input int v);
    if (v == 31) return 0;
    if (v >= 16) return 3500 - 100 * (v - 16);
    return 2050 - 50 * v;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (vid=%0d core=%0d)", req, act, expv, vid, core_mv);
    end
  endtask

  task automatic model_step();
    int r = exp_ref(int'(vid));
    longint c = longint'(core_mv) * 100;
    bit rails;
    if (vid == 5'd31) begin
      m_hi = 0; m_lo = 0;
    end else begin
      if (c > longint'(r) * 110) m_hi = 1; else if (c < longint'(r) * 108) m_hi = 0;
      if (c >= longint'(r) * 94) m_lo = 1; else if (c < longint'(r) * 92) m_lo = 0;
    end
    rails = (int'(lin_a_mv) * 4 >= 4500) && (int'(lin_b_mv) * 4 >= 5400) &&
            (aux_sel ? (int'(aux_mv) >= 2475) : (int'(aux_mv) * 4 >= 4500));
    m_pg = ss_done && ((vid == 5'd31) || (m_lo && !m_hi && rails));
    m_ov = (vid != 5'd31) && (c > longint'(r) * 115);
  endtask

  task automatic strobe(input string req);
    smp = 1'b1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    smp = 1'b0;
    chk({req, " pgood"}, int'(pgood), int'(m_pg));
    chk({req, " ovp"}, int'(ovp), int'(m_ov));
  endtask

  task automatic good_rails();
    lin_a_mv = W'(1500); lin_b_mv = W'(1800); aux_mv = W'(1500); aux_sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ks[17] = '{80, 91, 93, 95, 100, 107, 109, 110, 111, 109, 107, 100, 93, 91, 93, 116, 100};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset pgood", int'(pgood), 0);
    chk("R11 reset ovp", int'(ovp), 0);

    // R1 R2 R3: reference decode over all codes
    for (int v = 0; v < 32; v++) begin
      vid = 5'(v);
      #1;
      chk(v == 31 ? "R3 ref" : (v >= 16 ? "R2 ref" : "R1 ref"), int'(ref_mv), exp_ref(v));
    end

    // R4 R5 R8: sweep core through both hysteresis bands for every code
    ss_done = 1'b1;
    good_rails();
    for (int v = 0; v < 32; v++) begin
      vid = 5'(v);
      for (int i = 0; i < 17; i++) begin
        core_mv = W'(exp_ref(v) * ks[i] / 100);
        if (v == 31) core_mv = W'(1000 + 300 * i);
        strobe(v == 31 ? "R3" : (ks[i] > 100 ? "R4/R8" : "R5"));
      end
    end

    // R6 R7: rail under-voltage boundaries at vid 01010 (ref 1550)
    vid = 5'b01010; core_mv = W'(1550);
    strobe("R5 settle");
    lin_a_mv = W'(1124); strobe("R6 rail A below");
    lin_a_mv = W'(1125); strobe("R6 rail A at level");
    lin_b_mv = W'(1349); strobe("R6 rail B below");
    lin_b_mv = W'(1350); strobe("R6 rail B at level");
    aux_mv = W'(1124); strobe("R7 aux sel0 below");
    aux_mv = W'(1125); strobe("R7 aux sel0 at level");
    aux_sel = 1'b1; strobe("R7 aux sel1 low");
    aux_mv = W'(2474); strobe("R7 aux sel1 below");
    aux_mv = W'(2475); strobe("R7 aux sel1 at level");
    good_rails();
    strobe("R6 all good");

    // R9: soft-start gating, including the reserved code
    ss_done = 1'b0; strobe("R9 ss low");
    vid = 5'd31; strobe("R9 ss low reserved");
    ss_done = 1'b1; strobe("R3 reserved good");
    vid = 5'b01010; core_mv = W'(1500); strobe("R5 reserved restart");

    // R10: no strobe, inputs swing, outputs hold
    core_mv = W'(1550); strobe("R10 baseline");
    core_mv = W'(3000); lin_a_mv = W'(0); ss_done = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R10 hold pgood", int'(pgood), int'(m_pg));
      chk("R10 hold ovp", int'(ovp), int'(m_ov));
    end
    ss_done = 1'b1; lin_a_mv = W'(1500);
    strobe("R8 over after hold");

    // R11: reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_hi = 0; m_lo = 0; m_pg = 0; m_ov = 0;
    chk("R11 mid reset pgood", int'(pgood), 0);
    chk("R11 mid reset ovp", int'(ovp), 0);
    core_mv = W'(1560); strobe("R11 after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule